// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller of a five-stage integer pipeline (fetch, decode/register read, execute, memory, write back) with separate instruction and data memories. It is purely combinational. It compares the source register numbers of the instructions in decode and execute with the destination numbers held in the execute/memory and memory/writeback pipeline registers. From these comparisons it picks a bypass source for each ALU operand and for each operand of the branch comparator, which sits in decode.

It also decides when the front of the pipe must pause. A consumer placed directly after a load costs one stall cycle. A branch whose operand is still being produced in execute, or is still being loaded in the memory stage, waits until the value can be bypassed. Branches are predicted not taken. When the decode-stage comparator reports a taken branch, the block discards the one sequentially fetched instruction. Since instruction fetch uses its own memory, loads and stores never stall the fetch.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: An execute-stage operand whose register equals the destination in the execute/memory register, with that register's write enable set, gets select code 2'b10.
- R2: Otherwise, if the operand matches the memory/writeback destination with write enable set, the select is 2'b01. With no match the select is 2'b00, meaning the register file.
- R3: When both the execute/memory and memory/writeback destinations match, the execute/memory source (2'b10) wins.
- R4: A producer with its write enable low never causes a bypass. When ZERO_HW is 1, destination register 0 never causes a bypass either.
- R5: A load in execute whose destination matches a used source of the decode instruction stalls the pipe. The stall sets pc_we=0 and ifid_we=0 and idex_bubble=1.
- R6: A decode source whose use flag is 0 never causes a stall.
- R7: A branch in decode stalls when one of its used sources matches the execute-stage destination, whether that producer is an ALU operation or a load.
- R8: A branch stalls when it depends on a load in the memory stage. If it depends on an ALU result in the memory stage, it does not stall, and its comparator select is 2'b10.
- R9: A taken branch in decode with no stall sets ifid_flush=1 while pc_we and ifid_we stay 1. A branch that is not taken causes no flush.
- R10: A stall suppresses the flush, even when br_taken is 1.
- R11: With no hazard: pc_we=1, ifid_we=1, idex_bubble=0 and ifid_flush=0.
- R12: The branch comparator selects use the decode source numbers with the same codes and priority as in R1 to R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | AW | first source register of decode instruction |
| id_rs2 | input | AW | second source register of decode instruction |
| id_use1 | input | 1 | decode instruction reads id_rs1 |
| id_use2 | input | 1 | decode instruction reads id_rs2 |
| id_branch | input | 1 | decode instruction is a conditional branch |
| br_taken | input | 1 | decode comparator outcome: branch taken |
| ex_rs1 | input | AW | first source register in execute |
| ex_rs2 | input | AW | second source register in execute |
| ex_rd | input | AW | destination register in execute |
| ex_wen | input | 1 | execute instruction writes a register |
| ex_load | input | 1 | execute instruction is a load |
| mem_rd | input | AW | destination in execute/memory register |
| mem_wen | input | 1 | execute/memory instruction writes a register |
| mem_load | input | 1 | execute/memory instruction is a load |
| wb_rd | input | AW | destination in memory/writeback register |
| wb_wen | input | 1 | memory/writeback instruction writes a register |
| ex_fwd_a | output | 2 | bypass select, ALU operand A |
| ex_fwd_b | output | 2 | bypass select, ALU operand B |
| id_fwd_a | output | 2 | bypass select, comparator operand A |
| id_fwd_b | output | 2 | bypass select, comparator operand B |
| pc_we | output | 1 | program counter update enable |
| ifid_we | output | 1 | fetch/decode register write enable |
| idex_bubble | output | 1 | load an all-zero control bubble into decode/execute |
| ifid_flush | output | 1 | clear the fetch/decode register |

## Verification
The bench builds the block with AW=3 and ZERO_HW=1, so there are only eight register numbers. Random source and destination fields therefore collide often. Double matches that exercise the priority rule, producers aimed at register 0, and a load feeding a branch all occur often in the random stream. They do not have to be set up one by one. Directed vectors then pin down the load-use, branch-wait and flush-suppression cases explicitly.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;
  localparam int MAX_AW = 8;

  typedef enum logic [1:0] {
    SEL_REGFILE = 2'b00,
    SEL_WB      = 2'b01,
    SEL_MEM     = 2'b10
  } byp_sel_e;

  // a producer hits a consumer source when it writes and the numbers agree
  function automatic logic dest_hits(input logic [MAX_AW-1:0] rd,
                                     input logic wen,
                                     input logic [MAX_AW-1:0] src,
                                     input logic zero_hw);
    return wen && (rd == src) && !(zero_hw && (rd == '0));
  endfunction

  // younger result (execute/memory) first
  function automatic byp_sel_e pick_source(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return SEL_MEM;
    else if (wb_hit) return SEL_WB;
    else             return SEL_REGFILE;
  endfunction
endpackage

// File: rtl/byp_select.sv
module byp_select
  import pipe_hazard_pkg::*;
#(
  parameter int AW      = 5,
  parameter int N_OPS   = 2,
  parameter bit ZERO_HW = 1'b1
) (
  input  logic [N_OPS-1:0][AW-1:0] src,
  input  logic [AW-1:0]            mem_rd,
  input  logic                     mem_wen,
  input  logic [AW-1:0]            wb_rd,
  input  logic                     wb_wen,
  output logic [N_OPS-1:0][1:0]    sel
);
  for (genvar g = 0; g < N_OPS; g++) begin : g_op
    logic mem_hit;
    logic wb_hit;
    byp_sel_e pick;
    always_comb begin
      mem_hit = dest_hits(MAX_AW'(mem_rd), mem_wen, MAX_AW'(src[g]), ZERO_HW);
      wb_hit  = dest_hits(MAX_AW'(wb_rd),  wb_wen,  MAX_AW'(src[g]), ZERO_HW);
      pick    = pick_source(mem_hit, wb_hit);
      sel[g]  = pick;
    end
  end
endmodule

// File: rtl/stall_detect.sv
module stall_detect
  import pipe_hazard_pkg::*;
#(
  parameter int AW      = 5,
  parameter bit ZERO_HW = 1'b1
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic          id_branch,
  input  logic          br_taken,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  output logic          load_use_hit,
  output logic          br_wait,
  output logic          stall,
  output logic          redirect
);
  logic ex_dep;
  logic mem_dep;

  always_comb begin
    ex_dep  = (id_use1 && dest_hits(MAX_AW'(ex_rd), ex_wen, MAX_AW'(id_rs1), ZERO_HW)) ||
              (id_use2 && dest_hits(MAX_AW'(ex_rd), ex_wen, MAX_AW'(id_rs2), ZERO_HW));
    mem_dep = (id_use1 && dest_hits(MAX_AW'(mem_rd), mem_wen, MAX_AW'(id_rs1), ZERO_HW)) ||
              (id_use2 && dest_hits(MAX_AW'(mem_rd), mem_wen, MAX_AW'(id_rs2), ZERO_HW));
    load_use_hit = ex_load && ex_dep;
    br_wait      = id_branch && (ex_dep || (mem_load && mem_dep));
    stall        = load_use_hit || br_wait;
    redirect     = id_branch && br_taken && !stall;
  end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hazard_pkg::*;
#(
  parameter int AW      = 5,
  parameter bit ZERO_HW = 1'b1
) (
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_use1,
  input  logic          id_use2,
  input  logic          id_branch,
  input  logic          br_taken,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    ex_fwd_a,
  output logic [1:0]    ex_fwd_b,
  output logic [1:0]    id_fwd_a,
  output logic [1:0]    id_fwd_b,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          idex_bubble,
  output logic          ifid_flush
);
  localparam int N_OPS = 2;

  logic [N_OPS-1:0][AW-1:0] ex_src;
  logic [N_OPS-1:0][AW-1:0] id_src;
  logic [N_OPS-1:0][1:0]    ex_sel;
  logic [N_OPS-1:0][1:0]    id_sel;

  // named events for the checker
  logic load_use_hit;
  logic br_wait;
  logic stall;
  logic redirect;

  assign ex_src = {ex_rs2, ex_rs1};
  assign id_src = {id_rs2, id_rs1};

  // ALU operand bypass (R1..R4)
  byp_select #(.AW(AW), .N_OPS(N_OPS), .ZERO_HW(ZERO_HW)) u_ex_byp (
    .src(ex_src), .mem_rd(mem_rd), .mem_wen(mem_wen),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .sel(ex_sel)
  );

  // branch comparator bypass (R12)
  byp_select #(.AW(AW), .N_OPS(N_OPS), .ZERO_HW(ZERO_HW)) u_id_byp (
    .src(id_src), .mem_rd(mem_rd), .mem_wen(mem_wen),
    .wb_rd(wb_rd), .wb_wen(wb_wen), .sel(id_sel)
  );

  stall_detect #(.AW(AW), .ZERO_HW(ZERO_HW)) u_stall (
    .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use1(id_use1), .id_use2(id_use2),
    .id_branch(id_branch), .br_taken(br_taken),
    .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
    .load_use_hit(load_use_hit), .br_wait(br_wait),
    .stall(stall), .redirect(redirect)
  );

  assign ex_fwd_a    = ex_sel[0];
  assign ex_fwd_b    = ex_sel[1];
  assign id_fwd_a    = id_sel[0];
  assign id_fwd_b    = id_sel[1];
  assign pc_we       = !stall;
  assign ifid_we     = !stall;
  assign idex_bubble = stall;
  assign ifid_flush  = redirect;
endmodule

// File: rtl/pipe_hazard_chk.sv
module pipe_hazard_chk #(
  parameter int AW      = 5,
  parameter bit ZERO_HW = 1'b1
) (
  input logic [AW-1:0] id_rs1,
  input logic          id_use1,
  input logic          id_branch,
  input logic          br_taken,
  input logic [AW-1:0] ex_rs1,
  input logic [AW-1:0] ex_rd,
  input logic          ex_wen,
  input logic          ex_load,
  input logic [AW-1:0] mem_rd,
  input logic          mem_wen,
  input logic [1:0]    ex_fwd_a,
  input logic [1:0]    ex_fwd_b,
  input logic          pc_we,
  input logic          ifid_we,
  input logic          idex_bubble,
  input logic          ifid_flush,
  input logic          load_use_hit,
  input logic          br_wait
);
  always_comb begin
    AST_FWD_CODE_LEGAL: assert (ex_fwd_a != 2'b11 && ex_fwd_b != 2'b11); // R1
    if (ex_fwd_a == 2'b10)
      AST_MEM_SEL_SOURCE: assert (mem_wen && mem_rd == ex_rs1 &&
                                  !(ZERO_HW && mem_rd == '0)); // R4
    if (ex_load && ex_wen && id_use1 && ex_rd == id_rs1 && !(ZERO_HW && ex_rd == '0))
      AST_LOAD_USE_STALL: assert (load_use_hit && idex_bubble); // R5
    if (idex_bubble)
      AST_STALL_FREEZES: assert (!pc_we && !ifid_we); // R5
    if (br_wait)
      AST_BRANCH_WAIT: assert (id_branch && idex_bubble); // R7
    if (ifid_flush)
      AST_FLUSH_TAKEN: assert (id_branch && br_taken && pc_we); // R9
    if (ifid_flush)
      AST_FLUSH_NO_STALL: assert (!idex_bubble); // R10
  end
endmodule

bind pipe_hazard_ctrl pipe_hazard_chk #(.AW(AW), .ZERO_HW(ZERO_HW)) u_chk (.*);

// File: tb/pipe_hazard_ctrl_bench.sv
module pipe_hazard_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 3;
  localparam bit ZERO_HW = 1'b1;
  localparam int N_RANDOM = 3000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
  logic id_use1, id_use2, id_branch, br_taken, ex_wen, ex_load, mem_wen, mem_load, wb_wen;
  logic [1:0] ex_fwd_a, ex_fwd_b, id_fwd_a, id_fwd_b;
  logic pc_we, ifid_we, idex_bubble, ifid_flush;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  pipe_hazard_ctrl #(.AW(AW), .ZERO_HW(ZERO_HW)) u_pipe_hazard_ctrl (.*);

  // reference model written from the requirements
  function automatic bit writes(input logic [AW-1:0] d, input logic en, input logic [AW-1:0] s);
    if (!en) return 0;
    if (ZERO_HW && d == 0) return 0;
    return d == s;
  endfunction

  function automatic logic [1:0] want_sel(input logic [AW-1:0] s);
    if (writes(mem_rd, mem_wen, s)) return 2'b10;
    if (writes(wb_rd, wb_wen, s))   return 2'b01;
    return 2'b00;
  endfunction

  function automatic bit reads_from(input logic [AW-1:0] d, input logic en);
    return (id_use1 && writes(d, en, id_rs1)) || (id_use2 && writes(d, en, id_rs2));
  endfunction

  function automatic bit want_stall();
    bit lu, bw;
    lu = ex_load && reads_from(ex_rd, ex_wen);
    bw = id_branch && (reads_from(ex_rd, ex_wen) || (mem_load && reads_from(mem_rd, mem_wen)));
    return lu || bw;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
    {id_use1, id_use2, id_branch, br_taken, ex_wen, ex_load, mem_wen, mem_load, wb_wen} = '0;
  endtask

  function automatic string sel_tag(input logic [AW-1:0] s, input logic [1:0] e);
    if (e == 2'b10 && writes(wb_rd, wb_wen, s)) return "R3";
    if (e == 2'b10) return "R1";
    if (e == 2'b01) return "R2";
    return "R4";
  endfunction

  task automatic check_all();
    bit st;
    st = want_stall();
    check(sel_tag(ex_rs1, want_sel(ex_rs1)), ex_fwd_a, want_sel(ex_rs1));
    check(sel_tag(ex_rs2, want_sel(ex_rs2)), ex_fwd_b, want_sel(ex_rs2));
    check("R12 id_fwd_a", id_fwd_a, want_sel(id_rs1));
    check("R12 id_fwd_b", id_fwd_b, want_sel(id_rs2));
    check(st ? "R5/R7 pc_we" : "R11 pc_we", pc_we, !st);
    check(st ? "R5/R7 ifid_we" : "R11 ifid_we", ifid_we, !st);
    check(st ? "R5/R8 bubble" : "R11 bubble", idex_bubble, st);
    check(st ? "R10 flush" : "R9 flush", ifid_flush, id_branch && br_taken && !st);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clear_inputs();
    settle();
    // quiet state
    check("R11 pc_we", pc_we, 1);
    check("R11 ifid_we", ifid_we, 1);
    check("R11 bubble", idex_bubble, 0);
    check("R11 flush", ifid_flush, 0);
    check("R2 ex_fwd_a rf", ex_fwd_a, 2'b00);

    // R1, R3: both producers write r3, EX/MEM wins
    clear_inputs(); ex_rs1 = 3; mem_rd = 3; mem_wen = 1; wb_rd = 3; wb_wen = 1; settle();
    check("R3 priority", ex_fwd_a, 2'b10);
    // R2: only MEM/WB matches
    mem_wen = 0; settle();
    check("R2 wb bypass", ex_fwd_a, 2'b01);
    // R4: register 0 never bypassed
    clear_inputs(); ex_rs2 = 0; mem_rd = 0; mem_wen = 1; wb_rd = 0; wb_wen = 1; settle();
    check("R4 zero reg", ex_fwd_b, 2'b00);
    // R5: load-use
    clear_inputs(); ex_load = 1; ex_wen = 1; ex_rd = 5; id_rs2 = 5; id_use2 = 1; settle();
    check("R5 bubble", idex_bubble, 1);
    check("R5 pc_we", pc_we, 0);
    // R6: same, source unused
    id_use2 = 0; settle();
    check("R6 unused src", idex_bubble, 0);
    // R7: branch on ALU result in EX
    clear_inputs(); id_branch = 1; br_taken = 1; ex_wen = 1; ex_rd = 2; id_rs1 = 2; id_use1 = 1; settle();
    check("R7 branch wait", idex_bubble, 1);
    check("R10 no flush while stalled", ifid_flush, 0);
    // R8: load in MEM stalls; ALU in MEM bypasses
    clear_inputs(); id_branch = 1; mem_wen = 1; mem_load = 1; mem_rd = 4; id_rs2 = 4; id_use2 = 1; settle();
    check("R8 load in mem", idex_bubble, 1);
    mem_load = 0; settle();
    check("R8 alu in mem", idex_bubble, 0);
    check("R8 comparator sel", id_fwd_b, 2'b10);
    // R9: taken vs not taken
    clear_inputs(); id_branch = 1; br_taken = 1; settle();
    check("R9 flush", ifid_flush, 1);
    check("R9 pc_we", pc_we, 1);
    br_taken = 0; settle();
    check("R9 not taken", ifid_flush, 0);

    for (int i = 0; i < N_RANDOM; i++) begin
      id_rs1 = AW'($urandom); id_rs2 = AW'($urandom);
      ex_rs1 = AW'($urandom); ex_rs2 = AW'($urandom);
      ex_rd = AW'($urandom); mem_rd = AW'($urandom); wb_rd = AW'($urandom);
      id_use1 = 1'($urandom); id_use2 = 1'($urandom);
      id_branch = ($urandom % 3) == 0; br_taken = 1'($urandom);
      ex_wen = ($urandom % 4) != 0; ex_load = ($urandom % 3) == 0;
      mem_wen = ($urandom % 4) != 0; mem_load = ($urandom % 3) == 0;
      wb_wen = ($urandom % 4) != 0;
      settle();
      check_all();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule